// File: doc/BRIEF.md
# Bus Hold Requester

This block wins ownership of a shared parallel system bus for several internal engines: a bank of ISA DMA/bus-master request lines, a disk DMA engine and a USB host engine. It talks to an external arbiter over a two-wire sideband handshake. It drives an active-low hold request. The arbiter answers on an active-low hold-acknowledge input. Once the acknowledge has been sampled low, the block grants the bus to exactly one engine. For an ISA channel, it also raises that channel's DMA acknowledge.

When more than one engine is waiting, the winner is picked only while the hold request is idle. The order is fixed: ISA channels first (lowest channel number wins), then disk, then USB. The winner keeps the bus until it signals done or drops its request. The USB engine can run transactions back to back, but only while a latency timer has not run out. The timer is loaded from a programmable value at grant. After a release the block waits for the arbiter to drop its acknowledge before it asks again.

Top module: `bus_hold_req`

## Requirements
- R1: No grant and no DMA acknowledge is given before `hold_ack_n` has been sampled low at a clock edge while the hold request is active.
- R2: When any request is pending, the block is idle and `hold_ack_n` is high, `hold_req_n` goes low after the next clock edge.
- R3: `isa_dack` is one-hot or zero. It is nonzero only while `grant_isa` is high, and its set bit is the bit of the granted channel.
- R4: The winner is fixed at the moment the hold request is raised. ISA beats disk and disk beats USB, and the lowest ISA channel number wins among ISA channels. A request that arrives later does not change the winner.
- R5: With `lat_value` = L and no done, a USB grant lasts exactly L+1 clocks. `hold_req_n` is high on the clock after that.
- R6: A USB grant ends one clock after `usb_done` is sampled high, if that comes before timer expiry.
- R7: `hold_req_n` goes high one clock after the owner releases. The owner releases when its done input is high or its request is low.
- R8: After a release, `hold_req_n` stays high while `hold_ack_n` is low. It is raised again only after `hold_ack_n` has been sampled high.
- R9: If the chosen requester drops its request before the acknowledge arrives, `hold_req_n` is withdrawn on the next clock and no grant is issued.
- R10: During and right after reset, `hold_req_n` is high, all grants are low and `isa_dack` is zero.
- R11: At most one of `grant_isa`, `grant_disk`, `grant_usb` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| isa_dreq | input | N_ISA | Per-channel ISA DMA / bus-master request |
| isa_done | input | 1 | ISA owner finished |
| disk_req | input | 1 | Disk DMA request |
| disk_done | input | 1 | Disk DMA finished |
| usb_req | input | 1 | USB host engine request |
| usb_done | input | 1 | USB engine has no more transactions |
| lat_value | input | LAT_W | Latency timer reload value |
| hold_ack_n | input | 1 | Hold acknowledge from arbiter, active low |
| hold_req_n | output | 1 | Hold request to arbiter, active low |
| grant_isa | output | 1 | Bus granted to the ISA side |
| grant_disk | output | 1 | Bus granted to disk DMA |
| grant_usb | output | 1 | Bus granted to USB engine |
| isa_dack | output | N_ISA | Per-channel DMA acknowledge |

## Verification
On every cycle, the assertions check the following: grants come only after a sampled acknowledge, grants and acknowledges are one-hot, the owner stays fixed while busy, the hold request drops one clock after a release, withdrawal or timer expiry, and the block holds off while the acknowledge is still low. Some behaviours can only be shown by the bench scenarios. These are the priority order among simultaneous and late requests, the exact L+1 length of a USB grant for several timer values, and the full re-request sequence after the acknowledge drops.

// File: rtl/bhr_pkg.sv
package bhr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_HOLD, ST_OWN, ST_DRAIN} bhr_state_e;
  typedef enum logic [1:0] {SRC_ISA = 2'd0, SRC_DISK = 2'd1, SRC_USB = 2'd2, SRC_NONE = 2'd3} bhr_src_e;
endpackage

// File: rtl/bhr_prio.sv
module bhr_prio #(
  parameter int N_ISA = 4,
  localparam int CW = (N_ISA > 1) ? $clog2(N_ISA) : 1
) (
  input  logic [N_ISA-1:0] isa_dreq,
  input  logic             disk_req,
  input  logic             usb_req,
  output bhr_pkg::bhr_src_e src,
  output logic [CW-1:0]    chan
);
  import bhr_pkg::*;

  always_comb begin
    chan = '0;
    for (int i = N_ISA - 1; i >= 0; i--) begin
      if (isa_dreq[i]) chan = CW'(i);
    end
    if (|isa_dreq)    src = SRC_ISA;
    else if (disk_req) src = SRC_DISK;
    else if (usb_req)  src = SRC_USB;
    else               src = SRC_NONE;
  end
endmodule

// File: rtl/bhr_lat_timer.sv
module bhr_lat_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [LAT_W-1:0] load_val,
  output logic             expired
);
  logic [LAT_W-1:0] cnt;

  function automatic logic [LAT_W-1:0] step_down(input logic [LAT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= step_down(cnt);
  end

  assign expired = run && (cnt == '0);

  p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt != '0) |=> (cnt + 1'b1 == $past(cnt)));
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/bus_hold_req.sv
module bus_hold_req #(
  parameter int N_ISA = 4,
  parameter int LAT_W = 8,
  localparam int CW = (N_ISA > 1) ? $clog2(N_ISA) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_ISA-1:0] isa_dreq,
  input  logic             isa_done,
  input  logic             disk_req,
  input  logic             disk_done,
  input  logic             usb_req,
  input  logic             usb_done,
  input  logic [LAT_W-1:0] lat_value,
  input  logic             hold_ack_n,
  output logic             hold_req_n,
  output logic             grant_isa,
  output logic             grant_disk,
  output logic             grant_usb,
  output logic [N_ISA-1:0] isa_dack
);
  import bhr_pkg::*;

  bhr_state_e state;
  bhr_src_e   owner, pick_src;
  logic [CW-1:0] chan, pick_chan;

  logic any_req, sel_req, sel_done, tmr_exp;
  logic start_ev, grab_ev, withdraw_ev, release_ev, rearm_ev;

  bhr_prio #(.N_ISA(N_ISA)) u_prio (
    .isa_dreq(isa_dreq), .disk_req(disk_req), .usb_req(usb_req),
    .src(pick_src), .chan(pick_chan)
  );

  bhr_lat_timer #(.LAT_W(LAT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(grab_ev), .run(state == ST_OWN),
    .load_val(lat_value), .expired(tmr_exp)
  );

  assign any_req = (pick_src != SRC_NONE);

  always_comb begin
    case (owner)
      SRC_ISA:  begin sel_req = isa_dreq[chan]; sel_done = isa_done;  end
      SRC_DISK: begin sel_req = disk_req;       sel_done = disk_done; end
      SRC_USB:  begin sel_req = usb_req;        sel_done = usb_done || tmr_exp; end
      default:  begin sel_req = 1'b0;           sel_done = 1'b1;      end
    endcase
  end

  assign start_ev    = (state == ST_IDLE)  && any_req && hold_ack_n;
  assign withdraw_ev = (state == ST_HOLD)  && !sel_req;
  assign grab_ev     = (state == ST_HOLD)  && sel_req && !hold_ack_n;
  assign release_ev  = (state == ST_OWN)   && (sel_done || !sel_req);
  assign rearm_ev    = (state == ST_DRAIN) && hold_ack_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      owner <= SRC_NONE;
      chan  <= '0;
    end else begin
      if (start_ev) begin
        state <= ST_HOLD;
        owner <= pick_src;
        chan  <= pick_chan;
      end else if (withdraw_ev || release_ev) begin
        state <= ST_DRAIN;
      end else if (grab_ev) begin
        state <= ST_OWN;
      end else if (rearm_ev) begin
        state <= ST_IDLE;
        owner <= SRC_NONE;
      end
    end
  end

  assign hold_req_n = !((state == ST_HOLD) || (state == ST_OWN));
  assign grant_isa  = (state == ST_OWN) && (owner == SRC_ISA);
  assign grant_disk = (state == ST_OWN) && (owner == SRC_DISK);
  assign grant_usb  = (state == ST_OWN) && (owner == SRC_USB);

  always_comb begin
    isa_dack = '0;
    if (grant_isa) isa_dack[chan] = 1'b1;
  end

  p_grant_after_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_isa || grant_disk || grant_usb) |-> $past(!hold_ack_n && !hold_req_n));
  p_hold_on_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !hold_req_n);
  p_dack_in_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|isa_dack) |-> grant_isa);
  p_dack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isa_dack));
  p_owner_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE && $past(state != ST_IDLE)) |-> $stable(owner));
  p_usb_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_usb && tmr_exp) |=> hold_req_n);
  p_usb_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_usb && usb_done) |=> (!grant_usb && hold_req_n));
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> hold_req_n);
  p_no_rearm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && !hold_ack_n) |=> hold_req_n);
  p_withdraw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    withdraw_ev |=> (hold_req_n && !grant_isa && !grant_disk && !grant_usb));
  p_one_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant_isa, grant_disk, grant_usb}));
endmodule

// File: tb/sim_bus_hold_req.sv
module sim_bus_hold_req;
  localparam int CLK_PERIOD = 10;
  localparam int N_ISA = 4;
  localparam int LAT_W = 8;
  localparam int N_VEC = 6;
  // {isa_dreq[3:0], disk_req, usb_req, expected source (0 isa,1 disk,2 usb), expected dack[3:0]}
  localparam logic [11:0] VEC [N_VEC] = '{
    {4'b0001, 1'b0, 1'b0, 2'd0, 4'b0001},
    {4'b0100, 1'b1, 1'b1, 2'd0, 4'b0100},
    {4'b1010, 1'b0, 1'b1, 2'd0, 4'b0010},
    {4'b0000, 1'b1, 1'b1, 2'd1, 4'b0000},
    {4'b0000, 1'b0, 1'b1, 2'd2, 4'b0000},
    {4'b1000, 1'b1, 1'b0, 2'd0, 4'b1000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N_ISA-1:0] isa_dreq = '0;
  logic isa_done = 0, disk_req = 0, disk_done = 0, usb_req = 0, usb_done = 0;
  logic [LAT_W-1:0] lat_value = 8'd20;
  logic hold_ack_n = 1'b1;
  logic hold_req_n, grant_isa, grant_disk, grant_usb;
  logic [N_ISA-1:0] isa_dack;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_req #(.N_ISA(N_ISA), .LAT_W(LAT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .isa_dreq(isa_dreq), .isa_done(isa_done),
    .disk_req(disk_req), .disk_done(disk_done), .usb_req(usb_req), .usb_done(usb_done),
    .lat_value(lat_value), .hold_ack_n(hold_ack_n), .hold_req_n(hold_req_n),
    .grant_isa(grant_isa), .grant_disk(grant_disk), .grant_usb(grant_usb), .isa_dack(isa_dack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] gvec_of(input logic [1:0] s);
    return (s == 2'd0) ? 3'b100 : (s == 2'd1) ? 3'b010 : 3'b001;
  endfunction

  function automatic int count_usb_grant(input int limit);
    return limit;
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (2) tick();
    // R10: outputs idle during reset
    chk(hold_req_n && !grant_isa && !grant_disk && !grant_usb && isa_dack == 0, "R10 reset", hold_req_n, 1);
    rst_n = 1'b1;
    tick();
    chk(hold_req_n, "R10 after reset", hold_req_n, 1);

    for (int v = 0; v < N_VEC; v++) begin
      isa_dreq = VEC[v][11:8]; disk_req = VEC[v][7]; usb_req = VEC[v][6];
      tick();
      chk(!hold_req_n, "R2 hold raised", hold_req_n, 0);
      chk({grant_isa, grant_disk, grant_usb} == 3'b000, "R1 no grant before ack",
          {grant_isa, grant_disk, grant_usb}, 0);
      hold_ack_n = 1'b0;
      tick();
      chk({grant_isa, grant_disk, grant_usb} == gvec_of(VEC[v][5:4]), "R4 winner",
          {grant_isa, grant_disk, grant_usb}, gvec_of(VEC[v][5:4]));
      chk(isa_dack == VEC[v][3:0], "R3 dack", isa_dack, VEC[v][3:0]);
      case (VEC[v][5:4])
        2'd0: isa_done = 1;
        2'd1: disk_done = 1;
        default: usb_done = 1;
      endcase
      tick();
      chk(hold_req_n && {grant_isa, grant_disk, grant_usb} == 0, "R7/R6 release", hold_req_n, 1);
      isa_done = 0; disk_done = 0; usb_done = 0;
      isa_dreq = '0; disk_req = 0; usb_req = 0; hold_ack_n = 1'b1;
      tick();
    end

    // R5: USB grant length L+1 with L=3, then R8 hold-off while ack low
    lat_value = 8'd3; usb_req = 1;
    tick();
    hold_ack_n = 1'b0;
    tick();
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (!grant_usb) break;
      n++;
      tick();
    end
    chk(n == 4, "R5 usb grant length L=3", n, 4);
    chk(hold_req_n, "R5 hold dropped on expiry", hold_req_n, 1);
    repeat (3) tick();
    chk(hold_req_n, "R8 no re-hold while ack low", hold_req_n, 1);
    hold_ack_n = 1'b1;
    tick();
    chk(hold_req_n, "R8 idle after ack high", hold_req_n, 1);
    tick();
    chk(!hold_req_n, "R8 re-hold after ack high", hold_req_n, 0);
    // R9: withdraw before ack
    usb_req = 0;
    tick();
    chk(hold_req_n && !grant_usb, "R9 withdrawn", hold_req_n, 1);
    hold_ack_n = 1'b0;
    tick();
    chk(!grant_usb && hold_req_n, "R9 no grant after late ack", grant_usb, 0);
    hold_ack_n = 1'b1;
    tick();

    // R5: L=0 gives a single-cycle grant
    lat_value = 8'd0; usb_req = 1;
    tick();
    hold_ack_n = 1'b0;
    tick();
    n = 0;
    for (int k = 0; k < 10; k++) begin
      if (!grant_usb) break;
      n++;
      tick();
    end
    chk(n == 1, "R5 usb grant length L=0", n, 1);
    usb_req = 0; hold_ack_n = 1'b1;
    tick();

    // R4: late ISA request does not displace the chosen USB requester
    lat_value = 8'd20; usb_req = 1;
    tick();
    isa_dreq = 4'b0100; hold_ack_n = 1'b0;
    tick();
    chk(grant_usb && !grant_isa && isa_dack == 0, "R4 late request ignored", grant_usb, 1);
    usb_done = 1;
    tick();
    chk(hold_req_n, "R6 usb done release", hold_req_n, 1);
    usb_done = 0; usb_req = 0; hold_ack_n = 1'b1;
    tick();
    tick();
    chk(!hold_req_n, "R2 isa now requested", hold_req_n, 0);
    hold_ack_n = 1'b0;
    tick();
    chk(grant_isa && isa_dack == 4'b0100, "R3 isa dack channel 2", isa_dack, 4);
    chk(!grant_disk && !grant_usb, "R11 single grant", {grant_disk, grant_usb}, 0);
    // R7: release by dropping the request
    isa_dreq = '0;
    tick();
    chk(hold_req_n && isa_dack == 0, "R7 release on request drop", hold_req_n, 1);
    hold_ack_n = 1'b1;
    tick();

    // R10: reset while owning
    disk_req = 1;
    tick();
    hold_ack_n = 1'b0;
    tick();
    chk(grant_disk, "R4 disk grant", grant_disk, 1);
    rst_n = 1'b0;
    tick();
    chk(hold_req_n && !grant_disk, "R10 reset mid-grant", hold_req_n, 1);
    disk_req = 0; hold_ack_n = 1'b1; rst_n = 1'b1;
    tick();

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule